// File: doc/BRIEF.md
# NAND Large-Page Spare Regrouper

This block sits between a NAND byte stream and a page buffer. A 2 KB large page is read from the flash as four subpages of 528 bytes each. Each subpage carries 512 data bytes, then 6 free spare bytes, then 10 Reed-Solomon check bytes. The block takes that stream one byte per accepted cycle and emits the data bytes with their linear buffer address. It also files every spare byte into an internal 64-byte spare memory. In that memory, all free bytes are grouped at the front and all check bytes at the back.

Alongside the stream, a per-subpage decoder status word is presented. The block condenses the four status words into a page-level result: the worst corrected-error count, or a failure flag. It behaves differently in each of three modes:
- Full-page decode reports a failure.
- Spare-only decode turns an uncorrectable subpage into a count of five.
- Raw transfer ignores the status.

A one-cycle completion pulse marks the end of the page.

Top module: `nand_page_repack`

## Requirements
- R1: The data byte at offset j (0..511) of subpage i appears on `dout_byte` with `dout_addr` = 512*i + j and `dout_valid` high, one cycle after it is accepted. Data bytes come out in stream order.
- R2: Free byte k (0..5) of subpage i is stored at spare address 6*i + k. Spare addresses 0 and 1 therefore hold the bad-block marker bytes of subpage 0.
- R3: Check byte k (0..9) of subpage i is stored at spare address 24 + 10*i + k. It can be read through `spare_raddr`/`spare_rdata` once the page is complete.
- R4: The status word is sampled only with the last byte (offset 527) of each subpage. Its fields are:
  - bit 3 set means errors were corrected;
  - bits 5:4 hold the corrected count minus one;
  - bit 6 set means the subpage is uncorrectable.
  `result_flips` is the maximum corrected count over the four subpages.
- R5: In full-page decode mode (`mode` = 0), any uncorrectable subpage sets `result_fail`.
- R6: In spare-only mode (`mode` = 1), an uncorrectable subpage counts as 5 corrected errors. `result_fail` stays 0, and no data byte is emitted on `dout_valid`.
- R7: In raw mode (`mode` = 2 or 3), the status is ignored and the result is 0 errors with no failure. All 528 bytes per subpage are still emitted or filed as in R1 to R3.
- R8: `done` is high for exactly one cycle, the cycle after the 2112th byte is accepted. `result_flips` and `result_fail` are valid in that cycle and hold until the next start.
- R9: The block ignores the following inputs:
  - bytes presented while no page is open;
  - a `start` pulse while a page is open, which leaves the captured mode unchanged.
- R10: After reset, `dout_valid`, `done`, `result_flips` and `result_fail` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a page and captures `mode` |
| mode | input | 2 | 0 full decode, 1 spare-only decode, 2/3 raw |
| in_valid | input | 1 | A stream byte is presented |
| in_byte | input | 8 | Stream byte in flash order |
| sub_status | input | 8 | Decoder status of the current subpage |
| dout_valid | output | 1 | Data byte output is valid |
| dout_addr | output | 11 | Linear data buffer address |
| dout_byte | output | 8 | Data byte |
| spare_raddr | input | 6 | Spare memory read address |
| spare_rdata | output | 8 | Spare memory read data (combinational) |
| done | output | 1 | Page completion pulse |
| result_flips | output | 3 | Worst corrected-error count |
| result_fail | output | 1 | Page uncorrectable (full decode mode) |

## Verification
Three events land on the same clock edge: the final check byte of subpage 3 is written to spare address 63, the last status word is merged into the result, and the completion pulse is registered. The bench arranges for that last status to be the decisive one. It sets failures or large counts on subpage 3 and drives the inverted status on every other byte. `done`, `result_flips` and `result_fail` are then compared with independently computed values in the pulse cycle, and spare address 63 is read afterwards. A stray sample of a non-final byte, a result that lags one subpage behind, or a missing final write would each show up there.

// File: rtl/nand_repack_pkg.sv
package nand_repack_pkg;

  typedef enum logic [1:0] {
    RM_PAGE    = 2'd0,
    RM_SPARE   = 2'd1,
    RM_RAW     = 2'd2,
    RM_RAW_ALT = 2'd3
  } rp_mode_e;

  localparam int FLIP_W = 3;
  localparam logic [FLIP_W-1:0] UNCORR_FLIPS = 3'd5;

  // corrected count carried by one status word (0 when none flagged)
  function automatic logic [FLIP_W-1:0] rp_status_count(input logic [7:0] st);
    return st[3] ? ({1'b0, st[5:4]} + 3'd1) : 3'd0;
  endfunction

  function automatic logic rp_status_uncorr(input logic [7:0] st);
    return st[6];
  endfunction

endpackage

// File: rtl/rp_position.sv
module rp_position #(
  parameter int SUB_BYTES = 528,
  parameter int SUBPAGES  = 4,
  localparam int BW = $clog2(SUB_BYTES),
  localparam int SW = $clog2(SUBPAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [SW-1:0] sub_idx,
  output logic [BW-1:0] byte_idx,
  output logic          sub_last_byte,
  output logic          page_last
);

  logic [SW-1:0] sub_q, sub_d;
  logic [BW-1:0] byte_q, byte_d;

  assign sub_last_byte = (byte_q == BW'(SUB_BYTES - 1));
  assign page_last     = sub_last_byte && (sub_q == SW'(SUBPAGES - 1));
  assign sub_idx       = sub_q;
  assign byte_idx      = byte_q;

  always_comb begin
    sub_d  = sub_q;
    byte_d = byte_q;
    if (clear) begin
      sub_d  = '0;
      byte_d = '0;
    end else if (advance) begin
      if (sub_last_byte) begin
        byte_d = '0;
        sub_d  = sub_q + SW'(1);
      end else begin
        byte_d = byte_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      byte_q <= '0;
    end else begin
      sub_q  <= sub_d;
      byte_q <= byte_d;
    end
  end

  // R1: offset within a subpage never leaves the subpage
  a_r1_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    byte_q < BW'(SUB_BYTES));

endmodule

// File: rtl/rp_addr_map.sv
module rp_addr_map #(
  parameter int DATA_BYTES = 512,
  parameter int FREE_BYTES = 6,
  parameter int ECC_BYTES  = 10,
  parameter int SUBPAGES   = 4,
  localparam int SUB_BYTES   = DATA_BYTES + FREE_BYTES + ECC_BYTES,
  localparam int BW          = $clog2(SUB_BYTES),
  localparam int SW          = $clog2(SUBPAGES),
  localparam int DATA_AW     = $clog2(DATA_BYTES * SUBPAGES),
  localparam int SPARE_BYTES = (FREE_BYTES + ECC_BYTES) * SUBPAGES,
  localparam int SPW         = $clog2(SPARE_BYTES)
) (
  input  logic [SW-1:0]      sub_idx,
  input  logic [BW-1:0]      byte_idx,
  output logic               is_data,
  output logic [DATA_AW-1:0] data_addr,
  output logic [SPW-1:0]     spare_addr
);

  localparam int ECC_START   = DATA_BYTES + FREE_BYTES;
  localparam int ECC_SECTION = FREE_BYTES * SUBPAGES;

  int si, bi;
  assign si = int'(sub_idx);
  assign bi = int'(byte_idx);

  always_comb begin
    is_data   = (bi < DATA_BYTES);
    data_addr = DATA_AW'(si * DATA_BYTES + bi);
    if (bi < ECC_START)
      spare_addr = SPW'(si * FREE_BYTES + bi - DATA_BYTES);
    else
      spare_addr = SPW'(ECC_SECTION + si * ECC_BYTES + bi - ECC_START);
  end

endmodule

// File: rtl/rp_status_agg.sv
module rp_status_agg
  import nand_repack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  rp_mode_e          mode,
  input  logic [7:0]        status,
  output logic [FLIP_W-1:0] flips,
  output logic              fail
);

  logic [FLIP_W-1:0] flips_q, flips_d, cand;
  logic              fail_q, fail_d, unc;

  always_comb begin
    unc     = rp_status_uncorr(status);
    cand    = '0;
    fail_d  = fail_q;
    flips_d = flips_q;
    unique case (mode)
      RM_PAGE: begin
        cand = rp_status_count(status);
        if (sample && unc) fail_d = 1'b1;
      end
      RM_SPARE: cand = unc ? UNCORR_FLIPS : rp_status_count(status);
      default:  cand = '0;
    endcase
    if (sample && (cand > flips_q)) flips_d = cand;
    if (clear) begin
      flips_d = '0;
      fail_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flips_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      flips_q <= flips_d;
      fail_q  <= fail_d;
    end
  end

  assign flips = flips_q;
  assign fail  = fail_q;

  // R4: aggregated count never exceeds the uncorrectable substitute
  a_r4_flip_bound: assert property (@(posedge clk) disable iff (!rst_n)
    flips_q <= UNCORR_FLIPS);
  // R5: a failure can only be recorded under full-page decode
  a_r5_fail_page_only: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> (mode == RM_PAGE));

endmodule

// File: rtl/nand_page_repack.sv
module nand_page_repack
  import nand_repack_pkg::*;
#(
  parameter int DATA_BYTES = 512,
  parameter int FREE_BYTES = 6,
  parameter int ECC_BYTES  = 10,
  parameter int SUBPAGES   = 4,
  localparam int SUB_BYTES   = DATA_BYTES + FREE_BYTES + ECC_BYTES,
  localparam int BW          = $clog2(SUB_BYTES),
  localparam int SW          = $clog2(SUBPAGES),
  localparam int DATA_AW     = $clog2(DATA_BYTES * SUBPAGES),
  localparam int SPARE_BYTES = (FREE_BYTES + ECC_BYTES) * SUBPAGES,
  localparam int SPW         = $clog2(SPARE_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         mode,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  input  logic [7:0]         sub_status,
  output logic               dout_valid,
  output logic [DATA_AW-1:0] dout_addr,
  output logic [7:0]         dout_byte,
  input  logic [SPW-1:0]     spare_raddr,
  output logic [7:0]         spare_rdata,
  output logic               done,
  output logic [FLIP_W-1:0]  result_flips,
  output logic               result_fail
);

  logic               active_q, active_d;
  rp_mode_e           mode_q, mode_d;
  logic               start_take, accept;
  logic [SW-1:0]      sub_idx;
  logic [BW-1:0]      byte_idx;
  logic               sub_last_byte, page_last;
  logic               is_data;
  logic [DATA_AW-1:0] map_data_addr;
  logic [SPW-1:0]     map_spare_addr;
  logic               dout_en, spare_we;
  logic               dout_valid_q, done_q;
  logic [DATA_AW-1:0] dout_addr_q;
  logic [7:0]         dout_byte_q;
  logic [7:0]         spare_mem [SPARE_BYTES];

  assign start_take = start && !active_q;
  assign accept     = in_valid && active_q;
  assign dout_en    = accept && is_data && (mode_q != RM_SPARE);
  assign spare_we   = accept && !is_data;

  always_comb begin
    active_d = active_q;
    mode_d   = mode_q;
    if (start_take) begin
      active_d = 1'b1;
      mode_d   = rp_mode_e'(mode);
    end else if (accept && page_last) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mode_q   <= RM_PAGE;
    end else begin
      active_q <= active_d;
      mode_q   <= mode_d;
    end
  end

  rp_position #(.SUB_BYTES(SUB_BYTES), .SUBPAGES(SUBPAGES)) u_pos (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (start_take),
    .advance      (accept),
    .sub_idx      (sub_idx),
    .byte_idx     (byte_idx),
    .sub_last_byte(sub_last_byte),
    .page_last    (page_last)
  );

  rp_addr_map #(
    .DATA_BYTES(DATA_BYTES), .FREE_BYTES(FREE_BYTES),
    .ECC_BYTES(ECC_BYTES), .SUBPAGES(SUBPAGES)
  ) u_map (
    .sub_idx   (sub_idx),
    .byte_idx  (byte_idx),
    .is_data   (is_data),
    .data_addr (map_data_addr),
    .spare_addr(map_spare_addr)
  );

  rp_status_agg u_agg (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_take),
    .sample(accept && sub_last_byte),
    .mode  (mode_q),
    .status(sub_status),
    .flips (result_flips),
    .fail  (result_fail)
  );

  // registered data output with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_valid_q <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      dout_valid_q <= dout_en;
      done_q       <= accept && page_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_addr_q <= '0;
      dout_byte_q <= '0;
    end else if (dout_en) begin
      dout_addr_q <= map_data_addr;
      dout_byte_q <= in_byte;
    end
  end

  // regrouped spare storage, no reset (filled before use)
  always_ff @(posedge clk) begin
    if (spare_we) spare_mem[map_spare_addr] <= in_byte;
  end

  assign spare_rdata  = spare_mem[spare_raddr];
  assign dout_valid   = dout_valid_q;
  assign dout_addr    = dout_addr_q;
  assign dout_byte    = dout_byte_q;
  assign done         = done_q;

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: completion closes the page
  a_r8_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !active_q);
  // R6: spare-only decode never emits data and never fails
  a_r6_no_data_spare: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid_q |-> (mode_q != RM_SPARE));
  a_r6_spare_no_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q == RM_SPARE) |-> !result_fail);
  // R7: raw transfer always reports a clean page
  a_r7_raw_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (mode_q == RM_RAW || mode_q == RM_RAW_ALT))
      |-> (result_flips == '0 && !result_fail));
  // R9: mode is frozen while a page is open
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active_q) && active_q |-> $stable(mode_q));

endmodule

// File: tb/nand_page_repack_bench.sv
`timescale 1ns/1ps
module nand_page_repack_bench;

  logic       clk = 1'b0;
  logic       rst_n, start, in_valid;
  logic [1:0] mode;
  logic [7:0] in_byte, sub_status;
  logic       dout_valid, done, result_fail;
  logic [10:0] dout_addr;
  logic [7:0]  dout_byte, spare_rdata;
  logic [5:0]  spare_raddr;
  logic [2:0]  result_flips;

  int errors = 0;
  int checks = 0;
  int cur_seed = 0;
  int exp_addr = 0;
  int data_seen = 0;
  int done_seen = 0;

  always #2.5 clk = ~clk;

  nand_page_repack u_nand_page_repack (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .in_valid(in_valid), .in_byte(in_byte), .sub_status(sub_status),
    .dout_valid(dout_valid), .dout_addr(dout_addr), .dout_byte(dout_byte),
    .spare_raddr(spare_raddr), .spare_rdata(spare_rdata), .done(done),
    .result_flips(result_flips), .result_fail(result_fail)
  );

  function automatic logic [7:0] pat(input int sb, input int j, input int seed);
    return 8'((sb * 37 + j * 5 + seed * 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: data stream monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (dout_valid) begin
        chk(int'(dout_addr) == exp_addr, "R1 data address", int'(dout_addr), exp_addr);
        chk(dout_byte == pat(exp_addr / 512, exp_addr % 512, cur_seed),
            "R1 data byte", int'(dout_byte),
            int'(pat(exp_addr / 512, exp_addr % 512, cur_seed)));
        exp_addr++;
        data_seen++;
      end
      if (done) done_seen++;
    end
  end

  task automatic expect_res(input logic [1:0] md, input logic [31:0] stv,
                            output int ef, output int efail);
    ef = 0;
    efail = 0;
    for (int s = 0; s < 4; s++) begin
      logic [7:0] st;
      int c;
      st = stv[8*s +: 8];
      c  = st[3] ? int'(st[5:4]) + 1 : 0;
      if (md == 2'd0) begin
        if (st[6]) efail = 1;
      end else if (md == 2'd1) begin
        if (st[6]) c = 5;
      end else begin
        c = 0;
      end
      if (c > ef) ef = c;
    end
  endtask

  task automatic run_page(input string name, input logic [1:0] md,
                          input logic [31:0] stv, input int seed,
                          input bit gaps, input bit poke);
    int ef, efail, hold_f;
    cur_seed  = seed;
    exp_addr  = 0;
    data_seen = 0;
    done_seen = 0;
    expect_res(md, stv, ef, efail);
    @(negedge clk);
    start = 1'b1;
    mode  = md;
    @(negedge clk);
    start = 1'b0;
    mode  = ~md;
    for (int n = 0; n < 2112; n++) begin
      int sb, j;
      sb = n / 528;
      j  = n % 528;
      if (gaps && (n % 7 == 3)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid   = 1'b1;
      in_byte    = pat(sb, j, seed);
      sub_status = (j == 527) ? stv[8*sb +: 8] : ~stv[8*sb +: 8];
      start      = poke && (n == 1000); // R9: start during an open page
      @(negedge clk);
    end
    in_valid = 1'b0;
    start    = 1'b0;
    // R8: pulse and result on the cycle after the final byte
    chk(done == 1'b1, {"R8 done pulse ", name}, int'(done), 1);
    chk(int'(result_flips) == ef, {"R4 flips ", name}, int'(result_flips), ef);
    chk(int'(result_fail) == efail, {"R5 fail ", name}, int'(result_fail), efail);
    hold_f = int'(result_flips);
    @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, {"R8 done one cycle ", name}, int'(done), 0);
    chk(int'(result_flips) == hold_f, {"R8 result held ", name}, int'(result_flips), hold_f);
    chk(done_seen == 1, {"R8 single pulse count ", name}, done_seen, 1);
    chk(data_seen == ((md == 2'd1) ? 0 : 2048), {"R6 R7 data count ", name},
        data_seen, (md == 2'd1) ? 0 : 2048);
    // R2 / R3: regrouped spare contents
    for (int s = 0; s < 64; s++) begin
      int sb, j;
      if (s < 24) begin
        sb = s / 6;
        j  = 512 + s % 6;
      end else begin
        sb = (s - 24) / 10;
        j  = 518 + (s - 24) % 10;
      end
      spare_raddr = 6'(s);
      #1;
      chk(spare_rdata == pat(sb, j, seed), (s < 24) ? {"R2 free spare ", name} : {"R3 check spare ", name},
          int'(spare_rdata), int'(pat(sb, j, seed)));
    end
  endtask

  task automatic test_reset();
    chk(dout_valid == 1'b0, "R10 dout_valid", int'(dout_valid), 0);
    chk(done == 1'b0, "R10 done", int'(done), 0);
    chk(result_flips == 3'd0, "R10 flips", int'(result_flips), 0);
    chk(result_fail == 1'b0, "R10 fail", int'(result_fail), 0);
  endtask

  task automatic test_idle_ignore();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_byte    = 8'(k);
      sub_status = 8'h48;
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(dout_valid == 1'b0, "R9 idle bytes no data", int'(dout_valid), 0);
    chk(done == 1'b0 && result_fail == 1'b0, "R9 idle bytes no result",
        int'(done) + int'(result_fail), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 2'd0; in_valid = 1'b0;
    in_byte = 8'd0; sub_status = 8'd0; spare_raddr = 6'd0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_idle_ignore();
    run_page("page clean",        2'd0, 32'h00000000, 1, 1'b0, 1'b0);
    run_page("page corrected",    2'd0, 32'h00183808, 2, 1'b1, 1'b0);
    run_page("page uncorrectable",2'd0, 32'h48000008, 3, 1'b0, 1'b0);
    run_page("spare failure",     2'd1, 32'h00402800, 4, 1'b1, 1'b0);
    run_page("spare corrected",   2'd1, 32'h18000000, 5, 1'b0, 1'b0);
    run_page("raw",               2'd2, 32'h78787878, 6, 1'b1, 1'b0);
    run_page("raw alt start poke",2'd3, 32'h40384840, 7, 1'b0, 1'b1);
    run_page("last sub decisive", 2'd0, 32'h38000000, 8, 1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule